// File: doc/BRIEF.md
# Reservation Monitor for Load-Reserve / Store-Conditional

This block holds the single reservation a processor thread uses for atomic read-modify-write sequences built from a load-reserve and a later store-conditional. A load-reserve arms the monitor with a physical address and an access size. Writes by other agents arrive on a snoop port and cancel the reservation when they hit the reserved address exactly. A store-conditional is judged in the same cycle it is presented, against the reservation as it stood at the last clock edge.

The verdict has several parts. `sc_pass` gates the memory write, and the store reaches memory only when it is high. `sc_cr` is the 4-bit condition field for writeback. `sc_undef` flags a mismatch that lies inside the same 64 KiB region as the reservation, where the architectural outcome is undefined; such a store is reported as a failure. A registered count of consecutive failures gives a one-cycle warning pulse after every 100000th failure in a row, so that livelock can be seen.

The reservation is a two-state machine. Its states are `RSV_EMPTY` and `RSV_HELD`. The transitions are:
- arm: EMPTY to HELD on a load-reserve.
- re-arm: HELD to HELD on a load-reserve, which replaces the address and size.
- consume: HELD to EMPTY on a store-conditional with no load-reserve in the same cycle.
- snoop-kill: HELD to EMPTY on a snoop hit with no load-reserve in the same cycle.
- A load-reserve outranks every other event in its cycle.

Top module: `resv_monitor`

## Requirements
- R1: A load-reserve (`lr_valid`) moves the monitor to HELD and records `lr_addr` and `lr_size`. The size is encoded 00=1, 01=2, 10=4, 11=8 bytes.
- R2: While HELD, a snoop whose address equals the reserved address exactly clears the reservation. A snoop to any other address leaves the reservation intact.
- R3: When a load-reserve and a snoop to the same address arrive in one cycle, the new reservation is kept.
- R4: `sc_pass` is high only when a reservation is held, the store size equals the reserved size and the store address equals the reserved address.
- R5: `sc_undef` is high for a store-conditional that meets all of these: a reservation is held, size or address differs, and address bits above bit 15 match the reservation. The store then fails.
- R6: Every store-conditional consumes the reservation, whether it passes or fails. A second store-conditional fails unless a new load-reserve comes first.
- R7: `sc_cr` is 4'b0010 OR `so_bit` on success. On failure it is `so_bit` in bit 0 with bits 3..1 zero.
- R8: `sc_pass` is never high without `sc_valid`, so a failed or absent store never asserts the memory write strobe.
- R9: `fail_count` goes to 0 the cycle after a passing store-conditional. It goes up by one the cycle after a failing one, and it saturates at all ones.
- R10: `livelock_warn` pulses for one cycle, in the same cycle `fail_count` shows a multiple of 100000 consecutive failures.
- R11: After reset there is no reservation and `fail_count` is 0, so the first store-conditional fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lr_valid | input | 1 | Load-reserve request |
| lr_addr | input | AW | Physical address of the load-reserve |
| lr_size | input | 2 | Load-reserve size code |
| sc_valid | input | 1 | Store-conditional request |
| sc_addr | input | AW | Physical address of the store-conditional |
| sc_size | input | 2 | Store-conditional size code |
| snoop_valid | input | 1 | Write by another agent observed |
| snoop_addr | input | AW | Address of the snooped write |
| so_bit | input | 1 | Current summary-overflow bit |
| sc_pass | output | 1 | Store may go to memory (write strobe gate) |
| sc_undef | output | 1 | Mismatch inside the reservation's 64 KiB region |
| sc_cr | output | 4 | Condition field for writeback |
| fail_count | output | 32 | Saturating consecutive-failure count |
| livelock_warn | output | 1 | One-cycle pulse at each multiple of 100000 failures |

## Verification
`sc_pass`, `sc_undef` and `sc_cr` are combinational in the cycle of the store-conditional. The bench drives each request just after a falling edge and checks these outputs 1 ns later, before the rising edge that consumes the reservation. Reservation changes from load-reserves and snoops take effect at the next rising edge, so every probe store is issued in a later cycle. `fail_count` and `livelock_warn` are registered one edge behind the store and are checked at the following falling edge. In the warning scenario the store-conditional is held for 100001 cycles, and each falling edge is compared with the failure count expected at that point.

// File: rtl/resv_pkg.sv
package resv_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_DWORD = 2'b11
    } acc_size_e;

    typedef enum logic {
        RSV_EMPTY = 1'b0,
        RSV_HELD  = 1'b1
    } rsv_state_e;

    localparam int CR_W = 4;

endpackage

// File: rtl/resv_tracker.sv
module resv_tracker
    import resv_pkg::*;
#(
    parameter int AW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lr_valid,
    input  logic [AW-1:0] lr_addr,
    input  logic [1:0]    lr_size,
    input  logic          sc_valid,
    input  logic          snoop_valid,
    input  logic [AW-1:0] snoop_addr,
    output logic          rsv_valid,
    output logic [AW-1:0] rsv_addr,
    output logic [1:0]    rsv_size
);

    rsv_state_e    state_q, state_d;
    logic [AW-1:0] addr_q;
    logic [1:0]    size_q;
    logic          snoop_hit;

    assign snoop_hit = snoop_valid && (snoop_addr == addr_q);

    // Next-state: a load-reserve outranks consume and snoop-kill.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RSV_EMPTY: begin
                if (lr_valid) state_d = RSV_HELD;          // arm
            end
            RSV_HELD: begin
                if (lr_valid)                state_d = RSV_HELD;   // re-arm
                else if (sc_valid)           state_d = RSV_EMPTY;  // consume
                else if (snoop_hit)          state_d = RSV_EMPTY;  // snoop-kill
            end
            default: state_d = RSV_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RSV_EMPTY;
        else        state_q <= state_d;
    end

    // Reservation payload
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            size_q <= SZ_BYTE;
        end else if (lr_valid) begin
            addr_q <= lr_addr;
            size_q <= lr_size;
        end
    end

    // Outputs
    always_comb begin
        rsv_valid = (state_q == RSV_HELD);
        rsv_addr  = addr_q;
        rsv_size  = size_q;
    end

endmodule

// File: rtl/resv_judge.sv
module resv_judge
    import resv_pkg::*;
#(
    parameter int AW          = 64,
    parameter int REGION_BITS = 16
) (
    input  logic            rsv_valid,
    input  logic [AW-1:0]   rsv_addr,
    input  logic [1:0]      rsv_size,
    input  logic            sc_valid,
    input  logic [AW-1:0]   sc_addr,
    input  logic [1:0]      sc_size,
    input  logic            so_bit,
    output logic            pass,
    output logic            undef,
    output logic [CR_W-1:0] cr
);

    logic size_eq, addr_eq, region_eq, armed;

    always_comb begin
        armed     = sc_valid && rsv_valid;
        size_eq   = (sc_size == rsv_size);
        addr_eq   = (sc_addr == rsv_addr);
        region_eq = (sc_addr[AW-1:REGION_BITS] == rsv_addr[AW-1:REGION_BITS]);
        pass      = armed && size_eq && addr_eq;
        undef     = armed && !(size_eq && addr_eq) && region_eq;
        cr        = {2'b00, pass, so_bit};
    end

endmodule

// File: rtl/fail_tracker.sv
module fail_tracker #(
    parameter int CNT_W       = 32,
    parameter int WARN_PERIOD = 100000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sc_valid,
    input  logic             sc_pass,
    output logic [CNT_W-1:0] fail_count,
    output logic             warn
);

    localparam int               PER_W   = $clog2(WARN_PERIOD);
    localparam logic [PER_W-1:0] PER_TOP = PER_W'(WARN_PERIOD - 1);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [PER_W-1:0] per_q;
    logic             warn_q;
    logic             failed;

    assign failed = sc_valid && !sc_pass;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            per_q  <= '0;
            warn_q <= 1'b0;
        end else begin
            warn_q <= 1'b0;
            if (sc_valid && sc_pass) begin
                cnt_q <= '0;
                per_q <= '0;
            end else if (failed) begin
                if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
                if (per_q == PER_TOP) begin
                    per_q  <= '0;
                    warn_q <= 1'b1;
                end else begin
                    per_q <= per_q + PER_W'(1);
                end
            end
        end
    end

    assign fail_count = cnt_q;
    assign warn       = warn_q;

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
    import resv_pkg::*;
#(
    parameter int AW          = 64,
    parameter int REGION_BITS = 16,
    parameter int CNT_W       = 32,
    parameter int WARN_PERIOD = 100000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lr_valid,
    input  logic [AW-1:0]    lr_addr,
    input  logic [1:0]       lr_size,
    input  logic             sc_valid,
    input  logic [AW-1:0]    sc_addr,
    input  logic [1:0]       sc_size,
    input  logic             snoop_valid,
    input  logic [AW-1:0]    snoop_addr,
    input  logic             so_bit,
    output logic             sc_pass,
    output logic             sc_undef,
    output logic [3:0]       sc_cr,
    output logic [CNT_W-1:0] fail_count,
    output logic             livelock_warn
);

    logic          rsv_valid;
    logic [AW-1:0] rsv_addr;
    logic [1:0]    rsv_size;

    resv_tracker #(.AW(AW)) u_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .lr_valid   (lr_valid),
        .lr_addr    (lr_addr),
        .lr_size    (lr_size),
        .sc_valid   (sc_valid),
        .snoop_valid(snoop_valid),
        .snoop_addr (snoop_addr),
        .rsv_valid  (rsv_valid),
        .rsv_addr   (rsv_addr),
        .rsv_size   (rsv_size)
    );

    resv_judge #(.AW(AW), .REGION_BITS(REGION_BITS)) u_judge (
        .rsv_valid(rsv_valid),
        .rsv_addr (rsv_addr),
        .rsv_size (rsv_size),
        .sc_valid (sc_valid),
        .sc_addr  (sc_addr),
        .sc_size  (sc_size),
        .so_bit   (so_bit),
        .pass     (sc_pass),
        .undef    (sc_undef),
        .cr       (sc_cr)
    );

    fail_tracker #(.CNT_W(CNT_W), .WARN_PERIOD(WARN_PERIOD)) u_fail (
        .clk       (clk),
        .rst_n     (rst_n),
        .sc_valid  (sc_valid),
        .sc_pass   (sc_pass),
        .fail_count(fail_count),
        .warn      (livelock_warn)
    );

endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
    parameter int AW    = 64,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lr_valid,
    input logic [AW-1:0]    lr_addr,
    input logic             sc_valid,
    input logic             snoop_valid,
    input logic [AW-1:0]    snoop_addr,
    input logic             so_bit,
    input logic             sc_pass,
    input logic             sc_undef,
    input logic [3:0]       sc_cr,
    input logic [CNT_W-1:0] fail_count,
    input logic             livelock_warn,
    input logic             rsv_valid,
    input logic [AW-1:0]    rsv_addr
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    assert_lr_arms_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lr_valid |=> rsv_valid && (rsv_addr == $past(lr_addr)));

    assert_snoop_kills_R2: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_valid && !lr_valid && rsv_valid && (snoop_addr == rsv_addr) |=> !rsv_valid);

    assert_lr_beats_snoop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lr_valid && snoop_valid && (snoop_addr == lr_addr) |=> rsv_valid);

    assert_pass_excl_undef_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sc_pass |-> !sc_undef);

    assert_sc_consumes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sc_valid && !lr_valid |=> !sc_pass);

    assert_cr_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sc_valid |-> (sc_cr[3:2] == 2'b00) && (sc_cr[0] == so_bit));

    assert_pass_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sc_pass |-> sc_valid);

    assert_count_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sc_pass |=> fail_count == '0);

    assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sc_valid && !sc_pass && (fail_count != CNT_MAX) |=> fail_count == $past(fail_count) + CNT_W'(1));

    assert_count_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sc_valid && !sc_pass && (fail_count == CNT_MAX) |=> fail_count == CNT_MAX);

    assert_warn_after_fail_R10: assert property (@(posedge clk) disable iff (!rst_n)
        livelock_warn |-> fail_count != '0);

    assert_warn_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        livelock_warn |=> !livelock_warn);

endmodule

bind resv_monitor resv_monitor_chk #(.AW(AW), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lr_valid     (lr_valid),
    .lr_addr      (lr_addr),
    .sc_valid     (sc_valid),
    .snoop_valid  (snoop_valid),
    .snoop_addr   (snoop_addr),
    .so_bit       (so_bit),
    .sc_pass      (sc_pass),
    .sc_undef     (sc_undef),
    .sc_cr        (sc_cr),
    .fail_count   (fail_count),
    .livelock_warn(livelock_warn),
    .rsv_valid    (rsv_valid),
    .rsv_addr     (rsv_addr)
);

// File: tb/test_resv_monitor.sv
`timescale 1ns/1ps
module test_resv_monitor;

    localparam int AW = 64;
    localparam int CW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lr_valid = 1'b0;
    logic [AW-1:0] lr_addr = '0;
    logic [1:0]    lr_size = 2'b00;
    logic          sc_valid = 1'b0;
    logic [AW-1:0] sc_addr = '0;
    logic [1:0]    sc_size = 2'b00;
    logic          snoop_valid = 1'b0;
    logic [AW-1:0] snoop_addr = '0;
    logic          so_bit = 1'b0;
    logic          sc_pass, sc_undef, livelock_warn;
    logic [3:0]    sc_cr;
    logic [CW-1:0] fail_count;

    int  n_tests = 0;
    int  n_fail  = 0;
    int  exp_cnt = 0;
    bit  done    = 1'b0;

    always #2.5 clk = ~clk;

    resv_monitor i_resv_monitor (
        .clk(clk), .rst_n(rst_n),
        .lr_valid(lr_valid), .lr_addr(lr_addr), .lr_size(lr_size),
        .sc_valid(sc_valid), .sc_addr(sc_addr), .sc_size(sc_size),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .so_bit(so_bit),
        .sc_pass(sc_pass), .sc_undef(sc_undef), .sc_cr(sc_cr),
        .fail_count(fail_count), .livelock_warn(livelock_warn)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_lr(input logic [AW-1:0] a, input logic [1:0] s);
        @(negedge clk);
        lr_valid = 1'b1; lr_addr = a; lr_size = s;
        @(negedge clk);
        lr_valid = 1'b0;
    endtask

    task automatic do_snoop(input logic [AW-1:0] a);
        @(negedge clk);
        snoop_valid = 1'b1; snoop_addr = a;
        @(negedge clk);
        snoop_valid = 1'b0;
    endtask

    // Issue one store-conditional and check verdict, condition field and counter.
    task automatic do_sc(input string req, input logic [AW-1:0] a, input logic [1:0] s,
                         input logic so, input logic exp_pass, input logic exp_undef);
        @(negedge clk);
        sc_valid = 1'b1; sc_addr = a; sc_size = s; so_bit = so;
        #1;
        check({req, " pass"},  sc_pass,  exp_pass);
        check({req, " undef"}, sc_undef, exp_undef);
        check("R7 cr", sc_cr, exp_pass ? (4'b0010 | so) : {3'b000, so});
        @(negedge clk);
        sc_valid = 1'b0; so_bit = 1'b0;
        exp_cnt = exp_pass ? 0 : exp_cnt + 1;
        check("R9 fail_count", fail_count, exp_cnt);
    endtask

    localparam logic [AW-1:0] A = 64'h0000_0012_3456_0040;

    task automatic t_reset();
        check("R11 count after reset", fail_count, 0);
        check("R11 warn after reset", livelock_warn, 0);
        do_sc("R11 no reservation", A, 2'b10, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_exact();
        do_lr(A, 2'b10);
        do_sc("R4 exact word", A, 2'b10, 1'b0, 1'b1, 1'b0);
        do_lr(A + 64'h8, 2'b11);
        do_sc("R4 exact dword so", A + 64'h8, 2'b11, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_len();
        do_lr(A, 2'b10);
        do_sc("R5 length mismatch", A, 2'b11, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_far();
        do_lr(A, 2'b01);
        do_sc("R4 far address", A + 64'h1_0000, 2'b01, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_region();
        do_lr(A, 2'b00);
        do_sc("R5 same region", A + 64'h8, 2'b00, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_consume();
        do_lr(A, 2'b10);
        do_sc("R6 first", A, 2'b10, 1'b0, 1'b1, 1'b0);
        do_sc("R6 second fails", A, 2'b10, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_snoop();
        do_lr(A, 2'b10);
        do_snoop(A + 64'h4);
        do_sc("R2 other snoop no effect", A, 2'b10, 1'b0, 1'b1, 1'b0);
        do_lr(A, 2'b10);
        do_snoop(A);
        do_sc("R2 snoop kills", A, 2'b10, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_lr_snoop();
        @(negedge clk);
        lr_valid = 1'b1; lr_addr = A; lr_size = 2'b10;
        snoop_valid = 1'b1; snoop_addr = A;
        @(negedge clk);
        lr_valid = 1'b0; snoop_valid = 1'b0;
        do_sc("R3 lr beats snoop", A, 2'b10, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_strobe();
        do_lr(A, 2'b10);
        @(negedge clk);
        sc_addr = A; sc_size = 2'b10;
        #1;
        check("R8 no pass without request", sc_pass, 0);
        do_sc("R8 reservation still held", A, 2'b10, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_warn();
        int bad = 0;
        do_lr(A, 2'b10);
        do_sc("R10 clear counter", A, 2'b10, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        sc_valid = 1'b1; sc_addr = A; sc_size = 2'b10;
        for (int k = 1; k <= 100001; k++) begin
            @(negedge clk);
            if (fail_count != CW'(k)) bad++;
            if (k != 100000 && livelock_warn) bad++;
            if (k == 100000) check("R10 warn at 100000", livelock_warn, 1);
        end
        sc_valid = 1'b0;
        check("R10 no stray warn, R9 steady count", bad, 0);
        @(negedge clk);
        check("R10 warn single pulse", livelock_warn, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_exact();
        t_len();
        t_far();
        t_region();
        t_consume();
        t_snoop();
        t_lr_snoop();
        t_strobe();
        t_warn();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule